// File: doc/BRIEF.md
# Three-Stage Instruction Prefetch Queue

This block is the fetch front end of a processor with 16-bit instruction words. It reads words from memory over a simple request/ready bus, keeps a 20-bit extended program counter (4-bit bank over a 16-bit byte offset), and feeds a three-stage queue. New words land in stage A. They move to stage B, where the decoder evaluates the opcode. When the instruction finishes, its word is kept in stage C as the retired copy. A bus read latch holds one further word, so the counter always runs a fixed distance ahead of the executing instruction.

The queue advances only when the execute side reports completion, so only one instruction runs at a time. A change of flow loads the counter with the target address, discards the old-stream words in A, B and the read latch, and refills from the target. A read already on the bus when the redirect arrives finishes its bus cycle, but its data is thrown away.

The fetch controller is a four-state machine. In `F_IDLE` it issues a read at the counter on the next clock unless a redirect is present (IDLE->ADDR, or IDLE->IDLE on redirect). `F_ADDR` is the first clock of a bus cycle; mem_ready is ignored there (ADDR->WAIT always). `F_WAIT` waits for mem_ready. On ready it goes WAIT->HOLD if the word is kept, or WAIT->IDLE if the word is dropped. `F_HOLD` keeps the word in the read latch until stage A can take it. It then issues the next read in the same clock (HOLD->ADDR), or returns HOLD->IDLE on redirect.

Top module: `pfq_top`

## Requirements
- R1: While rst_n is low, mem_req and exe_ready are low and pc_out equals RESET_ADDR (default 0). The first read after reset is from RESET_ADDR.
- R2: A bus read holds mem_req high with mem_addr unchanged until mem_ready is seen. mem_ready is ignored in the first clock of the read, so a read lasts at least two clocks. mem_addr is always even.
- R3: exe_ready is high only when stages A and B both hold words of the current stream. It is low in the clock after a change of flow.
- R4: Whenever exe_ready is high, pc_out equals the byte address of the word in stage B plus 6.
- R5: The counter steps by 2 per issued read. The carry out of the 16-bit offset goes into the 4-bit bank, so 0x0FFFE is followed by 0x10000.
- R6: A clock with exe_done high while exe_ready is high moves B to C and A to B. exe_retired then shows the completed opcode until the next completion.
- R7: exe_opcode shows the stage B word, exe_ext shows the stage A word, and exe_byte shows bits 7:0 of the stage B word.
- R8: A clock with cof_req high loads pc_out with cof_target on the next edge and empties A and B. The instruction being executed is retired into C.
- R9: A read still on the bus when cof_req arrives keeps mem_req and mem_addr until its mem_ready. Its data never reaches stage A or B, and the first opcode after the redirect is the word at cof_target.
- R10: While exe_ready is high and neither exe_done nor cof_req is given, exe_opcode and exe_ext stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Bus read in progress |
| mem_addr | output | 20 | Byte address of the current read |
| mem_ready | input | 1 | Read data valid; ends the bus cycle |
| mem_rdata | input | 16 | Read data word |
| exe_ready | output | 1 | Stages A and B hold current-stream words |
| exe_opcode | output | 16 | Stage B word (opcode under evaluation) |
| exe_ext | output | 16 | Stage A word (operand extension) |
| exe_byte | output | 8 | Low byte of stage B (8-bit operand view) |
| exe_retired | output | 16 | Stage C word (last completed opcode) |
| exe_done | input | 1 | Current instruction complete |
| cof_req | input | 1 | Change of flow request |
| cof_target | input | 20 | Byte address of the new stream |
| pc_out | output | 20 | Extended program counter, bank:offset |

## Verification
Two events can fall in the same clock: a redirect, and the return of the read that would have filled the latch behind the executing instruction. The bench provokes this on purpose. It waits, during execution, for the clock in which the memory model raises mem_ready on the outstanding read, and drives cof_req in that very clock. It also sends redirects in clocks where the read is still waiting. The outcome is judged at the ports. The bus cycle must finish undisturbed, and the next instruction must show the target word in B and the following word in A, with pc_out at target plus 6. Words are hashed from their addresses, so any stale word that got through would show up as a mismatch.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_ADDR = 2'd1,
        F_WAIT = 2'd2,
        F_HOLD = 2'd3
    } fetch_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/pfq_fetch.sv
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned WORD_W = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    input  logic              pull,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] pc,
    output logic              lat_valid,
    output logic [WORD_W-1:0] lat_word
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / BYTE_W);

    fetch_state_e state, state_nx;
    logic [ADDR_W-1:0] bus_addr;
    logic drop;
    logic issue;
    logic landing;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        issue    = 1'b0;
        unique case (state)
            F_IDLE: begin
                if (!redirect) begin
                    state_nx = F_ADDR;
                    issue    = 1'b1;
                end
            end
            F_ADDR: state_nx = F_WAIT;
            F_WAIT: begin
                if (mem_ready) state_nx = (drop || redirect) ? F_IDLE : F_HOLD;
            end
            F_HOLD: begin
                if (redirect) state_nx = F_IDLE;
                else if (pull) begin
                    state_nx = F_ADDR;
                    issue    = 1'b1;
                end
            end
            default: state_nx = F_IDLE;
        endcase
    end

    assign landing = (state == F_WAIT) && mem_ready && !drop && !redirect;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= RESET_ADDR;
            bus_addr <= RESET_ADDR;
            drop     <= 1'b0;
            lat_word <= '0;
        end else begin
            if (redirect)   pc <= target;
            else if (issue) pc <= pc + STEP;
            if (issue) bus_addr <= pc;
            if ((state == F_WAIT) && mem_ready)
                drop <= 1'b0;
            else if (redirect && ((state == F_ADDR) || (state == F_WAIT)))
                drop <= 1'b1;
            if (landing) lat_word <= mem_rdata;
        end
    end

    assign mem_req   = (state == F_ADDR) || (state == F_WAIT);
    assign mem_addr  = bus_addr;
    assign lat_valid = (state == F_HOLD);

    // R2
    hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !((state == F_WAIT) && mem_ready)) |=> (mem_req && $stable(mem_addr)));

    // R2
    min_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |=> mem_req);

    // R8
    redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc == $past(target)));

    // R9
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && mem_ready && (state == F_WAIT)) |=> !lat_valid);

endmodule

// File: rtl/pfq_stages.sv
module pfq_stages #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_in,
    input  logic              flush,
    input  logic              lat_valid,
    input  logic [WORD_W-1:0] lat_word,
    output logic              pull,
    output logic              ready,
    output logic [WORD_W-1:0] a_word,
    output logic [WORD_W-1:0] b_word,
    output logic [WORD_W-1:0] c_word
);
    logic a_v, b_v;
    logic adv, b_load, a_to_b, a_load;

    assign ready  = a_v && b_v;
    assign adv    = done_in && ready && !flush;
    assign b_load = !b_v || adv;
    assign a_to_b = a_v && b_load;
    assign a_load = !a_v || a_to_b;
    assign pull   = lat_valid && a_load && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_v    <= 1'b0;
            b_v    <= 1'b0;
            a_word <= '0;
            b_word <= '0;
            c_word <= '0;
        end else if (flush) begin
            a_v <= 1'b0;
            b_v <= 1'b0;
            if (ready) c_word <= b_word;
        end else begin
            if (adv) c_word <= b_word;
            if (b_load) begin
                b_v <= a_v;
                if (a_v) b_word <= a_word;
            end
            if (a_load) begin
                a_v <= pull;
                if (pull) a_word <= lat_word;
            end
        end
    end

    // R6
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (c_word == $past(b_word)));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !ready);

    // R10
    hold_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !done_in && !flush) |=> ($stable(b_word) && $stable(a_word) && ready));

endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
    parameter int unsigned BANK_W = 4,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned WORD_W = 16,
    parameter logic [BANK_W+OFF_W-1:0] RESET_ADDR = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic                      mem_req,
    output logic [BANK_W+OFF_W-1:0]   mem_addr,
    input  logic                      mem_ready,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic                      exe_ready,
    output logic [WORD_W-1:0]         exe_opcode,
    output logic [WORD_W-1:0]         exe_ext,
    output logic [pfq_pkg::BYTE_W-1:0] exe_byte,
    output logic [WORD_W-1:0]         exe_retired,
    input  logic                      exe_done,
    input  logic                      cof_req,
    input  logic [BANK_W+OFF_W-1:0]   cof_target,
    output logic [BANK_W+OFF_W-1:0]   pc_out
);
    localparam int unsigned ADDR_W = BANK_W + OFF_W;

    logic              pull;
    logic              lat_valid;
    logic [WORD_W-1:0] lat_word;

    pfq_fetch #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (cof_req),
        .target   (cof_target),
        .pull     (pull),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .pc       (pc_out),
        .lat_valid(lat_valid),
        .lat_word (lat_word)
    );

    pfq_stages #(
        .WORD_W(WORD_W)
    ) u_stages (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_in  (exe_done),
        .flush    (cof_req),
        .lat_valid(lat_valid),
        .lat_word (lat_word),
        .pull     (pull),
        .ready    (exe_ready),
        .a_word   (exe_ext),
        .b_word   (exe_opcode),
        .c_word   (exe_retired)
    );

    assign exe_byte = exe_opcode[pfq_pkg::BYTE_W-1:0];

    // R2
    even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[0] == 1'b0));

endmodule

// File: tb/sim_pfq_top.sv
`timescale 1ns/1ps
module sim_pfq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        exe_ready;
    logic [15:0] exe_opcode, exe_ext, exe_retired;
    logic [7:0]  exe_byte;
    logic        exe_done = 1'b0;
    logic        cof_req = 1'b0;
    logic [19:0] cof_target = '0;
    logic [19:0] pc_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    pfq_top u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .exe_ready(exe_ready),
        .exe_opcode(exe_opcode), .exe_ext(exe_ext), .exe_byte(exe_byte),
        .exe_retired(exe_retired), .exe_done(exe_done), .cof_req(cof_req),
        .cof_target(cof_target), .pc_out(pc_out)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] wd(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], a[19:16], 8'h96} ^ {a[7:0], 8'h00};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // memory model with random wait clocks, sampled/driven on falling edges
    int  bus_cnt = 0;
    int  need = 2;
    bit  gave_ready = 1'b0;
    bit  first_fetch = 1'b1;
    logic [19:0] seen_addr;

    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (bus_cnt == 0) begin
                seen_addr = mem_addr;
                need = 2 + int'($urandom_range(0, 3));
                chk(mem_addr[0] == 1'b0, "R2 even address", 32'(mem_addr), 32'(mem_addr & 20'hFFFFE));
                if (first_fetch) begin
                    chk(mem_addr == 20'h0, "R1 first read address", 32'(mem_addr), 32'h0);
                    first_fetch = 1'b0;
                end
            end else if (mem_addr != seen_addr) begin
                chk(1'b0, "R2 address stable", 32'(mem_addr), 32'(seen_addr));
            end
            bus_cnt++;
            if (bus_cnt >= need) begin
                mem_ready = 1'b1;
                mem_rdata = wd(mem_addr);
                gave_ready = 1'b1;
            end else begin
                mem_ready = 1'b0;
            end
        end else begin
            if (rst_n && bus_cnt > 0 && !gave_ready)
                chk(1'b0, "R2 request held until ready", 32'(bus_cnt), 32'(need));
            mem_ready = 1'b0;
            bus_cnt = 0;
            gave_ready = 1'b0;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_ready();
        while (!exe_ready) step();
    endtask

    task automatic redirect(input logic [19:0] tgt, input string tag);
        bit inflight;
        logic [19:0] a0;
        inflight = mem_req && !mem_ready;
        a0 = mem_addr;
        cof_req = 1'b1;
        cof_target = tgt;
        step();
        cof_req = 1'b0;
        chk(pc_out == tgt, {tag, " R8 counter loaded"}, 32'(pc_out), 32'(tgt));
        chk(!exe_ready, "R3 ready low after redirect", 32'(exe_ready), 32'h0);
        if (inflight)
            chk(mem_req && mem_addr == a0, "R9 outstanding read continues", 32'(mem_addr), 32'(a0));
    endtask

    logic [19:0] exp_addr;
    logic [15:0] exp_ret;
    bit have_ret;

    initial begin
        void'($urandom(32'd1234));
        exp_addr = 20'h0;
        have_ret = 1'b0;
        repeat (3) step();
        chk(!mem_req, "R1 no request in reset", 32'(mem_req), 32'h0);
        chk(!exe_ready, "R1 not ready in reset", 32'(exe_ready), 32'h0);
        chk(pc_out == 20'h0, "R1 counter reset value", 32'(pc_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int n = 0; n < 400; n++) begin
            int hold;
            int pick;
            wait_ready();
            // execution start
            if (exp_addr[15:0] >= 16'hFFFA)
                chk(pc_out == exp_addr + 20'd6, "R5 bank carry", 32'(pc_out), 32'(exp_addr + 20'd6));
            else
                chk(pc_out == exp_addr + 20'd6, "R4 counter six ahead", 32'(pc_out), 32'(exp_addr + 20'd6));
            chk(exe_opcode == wd(exp_addr), "R7 opcode view", 32'(exe_opcode), 32'(wd(exp_addr)));
            chk(exe_ext == wd(exp_addr + 20'd2), "R7 extension view", 32'(exe_ext), 32'(wd(exp_addr + 20'd2)));
            chk(exe_byte == wd(exp_addr)[7:0], "R7 byte view", 32'(exe_byte), 32'(wd(exp_addr)[7:0]));
            if (have_ret)
                chk(exe_retired == exp_ret, "R6 retired copy held", 32'(exe_retired), 32'(exp_ret));
            hold = int'($urandom_range(0, 4));
            repeat (hold) step();
            chk(exe_ready && exe_opcode == wd(exp_addr) && exe_ext == wd(exp_addr + 20'd2),
                "R10 queue stable while executing", 32'(exe_opcode), 32'(wd(exp_addr)));
            pick = int'($urandom_range(0, 99));
            if (n == 10) begin
                exp_ret = wd(exp_addr);
                redirect(20'h0FFF8, "R5");
                exp_addr = 20'h0FFF8;
            end else if (n == 30 || (n > 30 && pick >= 85)) begin
                // R9: drive the redirect in the clock the pending read returns
                while (mem_req && !mem_ready) step();
                begin
                    logic [19:0] t;
                    t = 20'($urandom()) & 20'hFFFFE;
                    exp_ret = wd(exp_addr);
                    redirect(t, "R9");
                    exp_addr = t;
                end
            end else if (pick < 70) begin
                exp_ret = wd(exp_addr);
                exe_done = 1'b1;
                step();
                exe_done = 1'b0;
                chk(exe_retired == exp_ret, "R6 completed word retired", 32'(exe_retired), 32'(exp_ret));
                exp_addr = exp_addr + 20'd2;
            end else begin
                logic [19:0] t;
                t = 20'($urandom()) & 20'hFFFFE;
                exp_ret = wd(exp_addr);
                redirect(t, "R8");
                chk(exe_retired == exp_ret, "R8 redirecting word retired", 32'(exe_retired), 32'(exp_ret));
                exp_addr = t;
            end
            have_ret = 1'b1;
        end
        report();
    end

    initial begin
        #(20 * 200000);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        report();
    end
endmodule